// File: doc/BRIEF.md
# Dual-Mode Serial Converter Control

This block is the digital control of a serial sampling converter. The converter serves its host in one of two ways. In the pin-started way (mode 0), a falling edge on an active-low start pin runs a conversion of fixed length. During that time a busy flag is raised and the track/hold stage is held. The finished sample is latched and can then be read through the serial port. In the serial-driven way (mode 1), a falling edge on the active-low select pin samples the input, holds it and opens the data output. The serial clock then moves a 16-bit word out, one bit per falling edge.

The host never writes a mode register; the mode follows from how it behaves. A serial clock edge while a mode 0 conversion is running and the start pin is low moves the block into mode 1 and drops that conversion. In mode 1, a select pulse with no serial clock edges moves it back to mode 0. All three host pins are asynchronous to the system clock and are brought in through two-flop synchronisers before their edges are found. A parallel sample input stands in for the analog front end, and a counter stands in for the conversion time.

Top module: `conv_mode_ctrl`

## Requirements
- R1: After reset the block is in mode 0 (`serial_mode`=0) with `dout_en`=0, `hold_out`=0 (track), `busy`=0 and `pd_ok`=0.
- R2: In mode 0, a falling edge on `start_n` raises `busy` and `hold_out` for CONV_CYCLES system clocks. Both then fall and `sample_in` is latched as the result.
- R3: In mode 0, any `ser_clk` edge while `busy` is high and `start_n` is low switches the block to mode 1. It also clears `busy` and `hold_out` at once and leaves the latched result unchanged.
- R4: In mode 1, a falling edge of `sel_n` sets `hold_out`=1 and `dout_en`=1 and captures `sample_in`. The first frame bit, 0, is on `dout` before any `ser_clk` edge.
- R5: The frame is 16 bits: four 0 bits, then the 12-bit sample, MSB first. Each `ser_clk` falling edge while `sel_n` is low advances `dout` by one bit.
- R6: In mode 1, the 14th `ser_clk` falling edge of a frame returns `hold_out` to 0 (track).
- R7: The 16th `ser_clk` falling edge of a frame sets `dout_en` to 0.
- R8: A rise of `sel_n` before the 16th falling edge sets `dout_en`=0 and, in mode 1, `hold_out`=0. This ends the conversion.
- R9: In mode 1, `sel_n` going low and then high with no `ser_clk` edge in between returns the block to mode 0.
- R10: In mode 1, a `sel_n` low period that contains at least one `ser_clk` edge leaves the block in mode 1.
- R11: `pd_ok` is 1 only in mode 1 while `sel_n` is high and the output is disabled. It is never 1 in mode 0.
- R12: In mode 1, `start_n` has no effect: `busy` stays 0.
- R13: In mode 0, a `sel_n` low period clocked by `ser_clk` reads out the latched result in the R5 frame format, and the block stays in mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_n | input | 1 | Asynchronous active-low conversion start (mode 0) |
| sel_n | input | 1 | Asynchronous active-low select |
| ser_clk | input | 1 | Asynchronous serial clock from the host |
| sample_in | input | 12 | Parallel sample standing in for the analog result |
| hold_out | output | 1 | Track/hold control: 1 = hold, 0 = track |
| dout | output | 1 | Serial data bit (0 while disabled) |
| dout_en | output | 1 | Output enable for the three-state data pin |
| busy | output | 1 | Mode 0 conversion in progress |
| serial_mode | output | 1 | 0 = mode 0, 1 = mode 1 |
| pd_ok | output | 1 | Power-down may be requested |

## Verification
Some rules are checked by assertions on every cycle:
- `pd_ok` is confined to mode 1.
- `busy` never coexists with mode 1.
- An aborting clock edge flips the mode and clears `busy` on the next cycle.
- A select rise closes the output.
- A frame's last falling edge disables the output.
- A select rise after clocked traffic keeps mode 1.

Other behaviour appears only in the bench's scenarios:
- the exact bit order of the shifted word;
- the 14th-edge return to track;
- the length of a mode 0 conversion;
- that an aborted conversion leaves the earlier result in place;
- the round trip from mode 0 to mode 1 and back.

// File: rtl/cmc_pkg.sv
package cmc_pkg;
    localparam int unsigned SAMPLE_W   = 12;
    localparam int unsigned LEAD_ZEROS = 4;
    localparam int unsigned FRAME_W    = SAMPLE_W + LEAD_ZEROS;
    localparam int unsigned CNT_W      = $clog2(FRAME_W + 1);
    localparam int unsigned TRACK_AT   = 14;

    typedef enum logic {
        MODE_PIN    = 1'b0,
        MODE_SERIAL = 1'b1
    } mode_e;

    function automatic logic [FRAME_W-1:0] make_frame(input logic [SAMPLE_W-1:0] s);
        return {{LEAD_ZEROS{1'b0}}, s};
    endfunction
endpackage

// File: rtl/cmc_sync.sv
module cmc_sync #(
    parameter int unsigned N = 3,
    parameter logic [N-1:0] RESET_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] lvl,
    output logic [N-1:0] chg
);
    for (genvar i = 0; i < N; i++) begin : g_pin
        logic s1, s2, s3;
        always_ff @(posedge clk) begin
            if (rst) begin
                s1 <= RESET_VAL[i];
                s2 <= RESET_VAL[i];
                s3 <= RESET_VAL[i];
            end else begin
                s1 <= async_in[i];
                s2 <= s1;
                s3 <= s2;
            end
        end
        assign lvl[i] = s2;
        assign chg[i] = s2 ^ s3;
    end
endmodule

// File: rtl/cmc_conv_timer.sv
module cmc_conv_timer #(
    parameter int unsigned CONV_CYCLES = 413
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic abort,
    output logic busy,
    output logic done
);
    localparam int unsigned TW = $clog2(CONV_CYCLES + 1);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            done <= 1'b0;
            cnt  <= '0;
        end else begin
            done <= 1'b0;
            if (abort) begin
                busy <= 1'b0;
            end else if (start && !busy) begin
                busy <= 1'b1;
                cnt  <= TW'(CONV_CYCLES - 1);
            end else if (busy) begin
                if (cnt == '0) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
        end
    end

    // R3: an abort always ends the conversion without a result
    assert_abort_no_done_R3: assert property (@(posedge clk) disable iff (rst)
        abort |=> (!busy && !done));
endmodule

// File: rtl/cmc_shifter.sv
module cmc_shifter
    import cmc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [FRAME_W-1:0] load_word,
    input  logic               shift,
    input  logic               stop,
    output logic               sdata,
    output logic               oe,
    output logic [CNT_W-1:0]   fall_cnt
);
    logic [FRAME_W-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh       <= '0;
            oe       <= 1'b0;
            fall_cnt <= '0;
        end else if (load) begin
            sh       <= load_word;
            oe       <= 1'b1;
            fall_cnt <= '0;
        end else if (stop) begin
            oe <= 1'b0;
        end else if (shift && oe) begin
            sh       <= {sh[FRAME_W-2:0], 1'b0};
            fall_cnt <= fall_cnt + 1'b1;
            if (fall_cnt == CNT_W'(FRAME_W - 1)) oe <= 1'b0;
        end
    end

    assign sdata = sh[FRAME_W-1];

    // R7: the last falling edge of a frame disables the output
    assert_oe_done_R7: assert property (@(posedge clk) disable iff (rst)
        (oe && shift && !load && !stop && fall_cnt == CNT_W'(FRAME_W - 1)) |=> !oe);
endmodule

// File: rtl/conv_mode_ctrl.sv
module conv_mode_ctrl
    import cmc_pkg::*;
#(
    parameter int unsigned CONV_CYCLES = 413
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_n,
    input  logic                sel_n,
    input  logic                ser_clk,
    input  logic [SAMPLE_W-1:0] sample_in,
    output logic                hold_out,
    output logic                dout,
    output logic                dout_en,
    output logic                busy,
    output logic                serial_mode,
    output logic                pd_ok
);
    // synchronised pins: [2]=start_n, [1]=ser_clk, [0]=sel_n
    logic [2:0] s_lvl, s_chg;
    cmc_sync #(.N(3), .RESET_VAL(3'b101)) u_sync (
        .clk(clk), .rst(rst),
        .async_in({start_n, ser_clk, sel_n}),
        .lvl(s_lvl), .chg(s_chg)
    );

    logic start_low, start_fall, clk_edge, clk_fall, sel_low, sel_fall, sel_rise;
    assign start_low  = ~s_lvl[2];
    assign start_fall = s_chg[2] & ~s_lvl[2];
    assign clk_edge   = s_chg[1];
    assign clk_fall   = s_chg[1] & ~s_lvl[1];
    assign sel_low    = ~s_lvl[0];
    assign sel_fall   = s_chg[0] & ~s_lvl[0];
    assign sel_rise   = s_chg[0] & s_lvl[0];

    mode_e               mode;
    logic                edge_seen, hold_ser, conv_done, abort_pin, start_pin;
    logic [SAMPLE_W-1:0] result;
    logic [CNT_W-1:0]    fall_cnt;
    logic                sh_data;

    assign start_pin = (mode == MODE_PIN) && start_fall;
    assign abort_pin = (mode == MODE_PIN) && busy && start_low && clk_edge;

    cmc_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
        .clk(clk), .rst(rst), .start(start_pin), .abort(abort_pin),
        .busy(busy), .done(conv_done)
    );

    cmc_shifter u_shift (
        .clk(clk), .rst(rst),
        .load(sel_fall),
        .load_word((mode == MODE_SERIAL) ? make_frame(sample_in) : make_frame(result)),
        .shift(clk_fall && sel_low),
        .stop(sel_rise),
        .sdata(sh_data), .oe(dout_en), .fall_cnt(fall_cnt)
    );

    // mode tracking from host behaviour
    always_ff @(posedge clk) begin
        if (rst) begin
            mode      <= MODE_PIN;
            edge_seen <= 1'b0;
        end else if (abort_pin) begin
            mode      <= MODE_SERIAL;
            edge_seen <= 1'b0;
        end else if (mode == MODE_SERIAL) begin
            if (sel_fall)                 edge_seen <= 1'b0;
            else if (sel_low && clk_edge) edge_seen <= 1'b1;
            if (sel_rise && !edge_seen)   mode <= MODE_PIN;
        end
    end

    // serial-mode track/hold
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_ser <= 1'b0;
        end else if (mode != MODE_SERIAL || sel_rise) begin
            hold_ser <= 1'b0;
        end else if (sel_fall) begin
            hold_ser <= 1'b1;
        end else if (clk_fall && sel_low && dout_en && fall_cnt == CNT_W'(TRACK_AT - 1)) begin
            hold_ser <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)            result <= '0;
        else if (conv_done) result <= sample_in;
    end

    assign serial_mode = (mode == MODE_SERIAL);
    assign hold_out    = serial_mode ? hold_ser : busy;
    assign dout        = dout_en & sh_data;
    assign pd_ok       = serial_mode && !sel_low && !dout_en;

    // R1: reset state
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (!serial_mode && !dout_en && !busy));
    // R11: power-down permission only in mode 1
    assert_pd_serial_R11: assert property (@(posedge clk) disable iff (rst)
        pd_ok |-> serial_mode);
    // R3: clock edge during a mode 0 conversion
    assert_abort_switch_R3: assert property (@(posedge clk) disable iff (rst)
        (!serial_mode && busy && start_low && clk_edge) |=> (serial_mode && !busy));
    // R12: no conversion is ever busy in mode 1
    assert_no_busy_serial_R12: assert property (@(posedge clk) disable iff (rst)
        serial_mode |-> !busy);
    // R8: select rise closes the output and releases hold
    assert_sel_rise_R8: assert property (@(posedge clk) disable iff (rst)
        (sel_rise && serial_mode) |=> (!dout_en && !hold_out));
    // R10: clocked select period keeps mode 1
    assert_stay_serial_R10: assert property (@(posedge clk) disable iff (rst)
        (serial_mode && sel_rise && edge_seen) |=> serial_mode);
endmodule

// File: tb/conv_mode_ctrl_tb.sv
module conv_mode_ctrl_tb;
    localparam int CONV = 413;
    localparam logic [27:0] VEC [4] = '{
        {12'h000, 16'h0000},
        {12'hFFF, 16'h0FFF},
        {12'h9A6, 16'h09A6},
        {12'h5B1, 16'h05B1}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_n = 1'b1, sel_n = 1'b1, ser_clk = 1'b0;
    logic [11:0] sample_in = '0;
    logic hold_out, dout, dout_en, busy, serial_mode, pd_ok;
    int n_chk = 0, n_bad = 0;

    always #4 clk = ~clk;

    conv_mode_ctrl #(.CONV_CYCLES(CONV)) u_dut (
        .clk(clk), .rst(rst), .start_n(start_n), .sel_n(sel_n), .ser_clk(ser_clk),
        .sample_in(sample_in), .hold_out(hold_out), .dout(dout), .dout_en(dout_en),
        .busy(busy), .serial_mode(serial_mode), .pd_ok(pd_ok)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic read_frame(input logic [15:0] exp, input bit ser);
        sel_n = 1'b0;
        wait_clk(6);
        check("R4 output enabled", 32'(dout_en), 1);
        if (ser) check("R4 hold on select", 32'(hold_out), 1);
        check("R4 first bit", 32'(dout), 32'(exp[15]));
        for (int i = 0; i < 16; i++) begin
            ser_clk = 1'b1; wait_clk(4);
            ser_clk = 1'b0; wait_clk(5);
            if (i < 15) check("R5 frame bit", 32'(dout), 32'(exp[14-i]));
            if (ser && i == 12) check("R6 still hold at 13", 32'(hold_out), 1);
            if (ser && i == 13) check("R6 track at 14", 32'(hold_out), 0);
            if (i == 15) check("R7 disabled at 16", 32'(dout_en), 0);
        end
        sel_n = 1'b1;
        wait_clk(6);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        wait_clk(4);
        rst = 1'b0;
        wait_clk(1);
        check("R1 mode", 32'(serial_mode), 0);
        check("R1 enable", 32'(dout_en), 0);
        check("R1 hold", 32'(hold_out), 0);
        check("R1 busy", 32'(busy), 0);
        check("R1 pd", 32'(pd_ok), 0);

        // R2: mode 0 conversion
        sample_in = 12'hA5C;
        start_n = 1'b0;
        wait_clk(6);
        check("R2 busy", 32'(busy), 1);
        check("R2 hold", 32'(hold_out), 1);
        wait_clk(CONV - 10);
        check("R2 still busy", 32'(busy), 1);
        wait_clk(12);
        check("R2 busy done", 32'(busy), 0);
        check("R2 track", 32'(hold_out), 0);
        start_n = 1'b1;
        wait_clk(4);
        sample_in = 12'h111;
        // R13: mode 0 readout of latched result
        read_frame(16'h0A5C, 1'b0);
        check("R13 mode kept", 32'(serial_mode), 0);

        // R3: abort by clock edge
        sample_in = 12'h3C3;
        start_n = 1'b0;
        wait_clk(10);
        check("R3 busy before", 32'(busy), 1);
        ser_clk = 1'b1;
        wait_clk(6);
        check("R3 mode 1", 32'(serial_mode), 1);
        check("R3 busy cleared", 32'(busy), 0);
        check("R3 track", 32'(hold_out), 0);
        ser_clk = 1'b0;
        wait_clk(4);
        start_n = 1'b1;
        wait_clk(4);

        // mode 1 frames from table
        for (int v = 0; v < 4; v++) begin
            sample_in = VEC[v][27:16];
            read_frame(VEC[v][15:0], 1'b1);
            check("R10 stays mode 1", 32'(serial_mode), 1);
            check("R11 pd allowed", 32'(pd_ok), 1);
        end

        // R12: start pin ignored in mode 1
        start_n = 1'b0;
        wait_clk(8);
        check("R12 busy stays low", 32'(busy), 0);
        check("R12 mode kept", 32'(serial_mode), 1);
        start_n = 1'b1;
        wait_clk(4);

        // R8: early select rise
        sample_in = 12'h777;
        sel_n = 1'b0;
        for (int i = 0; i < 5; i++) begin
            ser_clk = 1'b1; wait_clk(4);
            ser_clk = 1'b0; wait_clk(4);
        end
        check("R8 enabled mid frame", 32'(dout_en), 1);
        check("R8 hold mid frame", 32'(hold_out), 1);
        sel_n = 1'b1;
        wait_clk(6);
        check("R8 disabled", 32'(dout_en), 0);
        check("R8 track", 32'(hold_out), 0);
        check("R10 mode after early rise", 32'(serial_mode), 1);

        // R9: select pulse without clock
        sel_n = 1'b0;
        wait_clk(6);
        sel_n = 1'b1;
        wait_clk(6);
        check("R9 back to mode 0", 32'(serial_mode), 0);
        check("R11 pd off in mode 0", 32'(pd_ok), 0);

        // R3: aborted conversion left old result
        sample_in = 12'hFFF;
        read_frame(16'h0A5C, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule